// File: doc/BRIEF.md
# Bus idle-cycle insertion controller

This block sits between a bus master's access request stream and an external memory bus shared by four chip-select areas. Slow devices, such as ROMs that are slow to release their read drivers, can still drive the shared data lines when the next access begins. The controller prevents that contention. Before each new access it decides whether dead clocks are needed. If they are, it stalls the request and then launches it.

A 16-bit control register holds one 2-bit idle code per area. The code gives the minimum number of dead clocks, on a 0, 1, 2, 4 scale. Idles are needed in two cases: the new access targets a different area from the last issued access, or a write follows a read to the same area. In both cases the count comes from the field of the area accessed last, not from the area of the new request. The low byte of the register holds per-area wait codes. These are stored and read back but have no effect here.

Top module: `bus_idle_gap_ctrl`

## Requirements
- R1: After reset:
  - `cfg_rdata` reads 16'hAAFF, so every idle code is 10.
  - `req_ready` is 1.
  - `bus_start` and `idle_active` are 0.
- R2: A write takes effect at the clock edge and reads back on `cfg_rdata` from the next cycle. `cfg_we[1]` loads bits 15:8 from `cfg_wdata` and `cfg_we[0]` loads bits 7:0. A byte whose enable is 0 keeps its value.
- R3: The idle code for area a sits at bits 9+2a:8+2a, so area 3 uses 15:14 and area 0 uses 9:8. Code 00 means no idle clock, 01 means one, 10 means two and 11 means four.
- R4: When an accepted request targets a different area than the last issued access, the idle clocks inserted equal the code of the last issued area.
- R5: When a write request follows a read issued to the same area, the idle clocks inserted equal that area's code.
- R6: No idle clock is inserted in these cases:
  - read after read to the same area;
  - write after write to the same area;
  - read after write to the same area;
  - the first access after reset.
- R7: A request is accepted in the cycle where `req_valid` and `req_ready` are both 1; call that cycle T. If n idle clocks are due:
  - `idle_active` is 1 and `req_ready` is 0 in cycles T+1 to T+n;
  - `bus_start` is 1 for the single cycle T+n+1, with `req_ready` back at 1.

  With n = 0, `bus_start` is 1 in cycle T+1.
- R8: In the `bus_start` cycle, `bus_area` and `bus_write` carry the area and direction of the accepted request. Input changes made while the idle clocks run do not alter them.
- R9: The idle count is fixed when the request is accepted. A register write made in the acceptance cycle or during the idle clocks does not change that access. It applies to requests accepted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 2 | Byte write enables for the control register |
| cfg_wdata | input | 16 | Control register write data |
| cfg_rdata | output | 16 | Control register contents |
| req_valid | input | 1 | Access request present |
| req_area | input | 2 | Target area of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request can be accepted this cycle |
| bus_start | output | 1 | One-cycle launch of the accepted access |
| bus_area | output | 2 | Area of the launched (and last issued) access |
| bus_write | output | 1 | Direction of the launched access |
| idle_active | output | 1 | Dead clock in progress |

## Verification
Some properties are checked on every cycle:
- no launch occurs during a dead clock;
- the end of an idle run is followed at once by a launch;
- the latched request stays still while the run lasts;
- a run is never shorter than the code captured at acceptance;
- accepted requests follow the change-of-area, read-to-write and same-kind rules.

Other behaviour shows only in the directed scenarios:
- the exact decode of each code value;
- the byte-lane register writes;
- the choice of the previous area's field rather than the new one's;
- the isolation of an access from register writes made in its acceptance cycle or during its idle clocks.

// File: rtl/bidl_pkg.sv
package bidl_pkg;
   localparam int FIELD_W = 2;
   localparam int CNT_W   = 3;

   typedef enum logic {ST_OPEN, ST_GAP} gap_state_e;

   // Non-linear idle code: 00->0, 01->1, 10->2, 11->4
   function automatic logic [CNT_W-1:0] idle_decode(input logic [FIELD_W-1:0] code);
      logic [CNT_W-1:0] n;
      case (code)
         2'b00:   n = 3'd0;
         2'b01:   n = 3'd1;
         2'b10:   n = 3'd2;
         default: n = 3'd4;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/bidl_cfg_reg.sv
module bidl_cfg_reg #(
   parameter int          REG_W     = 16,
   parameter logic [15:0] RESET_VAL = 16'hAAFF,
   localparam int         BYTES     = REG_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BYTES-1:0] we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] q
);
   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            q[8*b +: 8] <= RESET_VAL[8*b +: 8];
         else if (we[b])
            q[8*b +: 8] <= wdata[8*b +: 8];
      end
   end

   if (REG_W % 8 != 0) begin : g_bad_width
      initial $error("REG_W must be a whole number of bytes");
   end
endmodule

// File: rtl/bidl_decide.sv
module bidl_decide
   import bidl_pkg::*;
#(
   parameter int  NUM_AREAS = 4,
   localparam int AREA_W    = $clog2(NUM_AREAS),
   localparam int CODES_W   = NUM_AREAS * FIELD_W
) (
   input  logic [CODES_W-1:0] idle_codes,
   input  logic               has_prev,
   input  logic [AREA_W-1:0]  prev_area,
   input  logic               prev_write,
   input  logic [AREA_W-1:0]  req_area,
   input  logic               req_write,
   output logic [CNT_W-1:0]   gap_cnt
);
   logic [CNT_W-1:0] area_cnt [NUM_AREAS];

   for (genvar a = 0; a < NUM_AREAS; a++) begin : g_area
      assign area_cnt[a] = idle_decode(idle_codes[FIELD_W*a +: FIELD_W]);
   end

   logic area_change, rd_to_wr;

   always_comb begin
      area_change = (req_area != prev_area);
      rd_to_wr    = !prev_write && req_write;
      gap_cnt     = (has_prev && (area_change || rd_to_wr)) ? area_cnt[prev_area] : '0;
   end
endmodule

// File: rtl/bidl_gap_fsm.sv
module bidl_gap_fsm
   import bidl_pkg::*;
#(
   parameter int AREA_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   input  logic [CNT_W-1:0]  gap_cnt,
   output logic              req_ready,
   output logic              bus_start,
   output logic [AREA_W-1:0] bus_area,
   output logic              bus_write,
   output logic              idle_active,
   output logic              has_prev
);
   gap_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [AREA_W-1:0] pend_area;
   logic              pend_write;
   logic              accept;

   assign req_ready   = (state == ST_OPEN);
   assign idle_active = (state == ST_GAP);
   assign accept      = req_valid && req_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_OPEN;
         cnt        <= '0;
         pend_area  <= '0;
         pend_write <= 1'b0;
         bus_start  <= 1'b0;
         bus_area   <= '0;
         bus_write  <= 1'b0;
         has_prev   <= 1'b0;
      end else begin
         bus_start <= 1'b0;
         case (state)
            ST_OPEN: if (accept) begin
               if (gap_cnt == '0) begin
                  bus_start <= 1'b1;
                  bus_area  <= req_area;
                  bus_write <= req_write;
                  has_prev  <= 1'b1;
               end else begin
                  state      <= ST_GAP;
                  cnt        <= gap_cnt;
                  pend_area  <= req_area;
                  pend_write <= req_write;
               end
            end
            default: begin
               cnt <= cnt - 1'b1;
               if (cnt == 1) begin
                  state     <= ST_OPEN;
                  bus_start <= 1'b1;
                  bus_area  <= pend_area;
                  bus_write <= pend_write;
                  has_prev  <= 1'b1;
               end
            end
         endcase
      end
   end

   // Checker state: length of the current idle run and the count granted at acceptance
   logic [CNT_W:0]   run_len;
   logic [CNT_W-1:0] need_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         need_q  <= '0;
      end else if (accept) begin
         run_len <= '0;
         need_q  <= gap_cnt;
      end else if (idle_active) begin
         run_len <= run_len + 1'b1;
      end
   end

   AST_NO_START_IN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      idle_active |-> !bus_start); // R7
   AST_START_ENDS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_active) |-> bus_start); // R7
   AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_active && $past(idle_active)) |-> ($stable(pend_area) && $stable(pend_write))); // R8
   AST_GAP_MINIMUM: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(idle_active) |-> (run_len >= {1'b0, need_q})); // R9
endmodule

// File: rtl/bus_idle_gap_ctrl.sv
module bus_idle_gap_ctrl
   import bidl_pkg::*;
#(
   parameter int          NUM_AREAS = 4,
   parameter int          REG_W     = 16,
   parameter int          IDLE_LSB  = 8,
   parameter logic [15:0] RESET_VAL = 16'hAAFF,
   localparam int         AREA_W    = $clog2(NUM_AREAS),
   localparam int         BYTES     = REG_W / 8,
   localparam int         CODES_W   = NUM_AREAS * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTES-1:0]  cfg_we,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   input  logic              req_valid,
   input  logic [AREA_W-1:0] req_area,
   input  logic              req_write,
   output logic              req_ready,
   output logic              bus_start,
   output logic [AREA_W-1:0] bus_area,
   output logic              bus_write,
   output logic              idle_active
);
   if (IDLE_LSB + CODES_W != REG_W) begin : g_bad_layout
      initial $error("idle codes must fill the register above IDLE_LSB");
   end
   if ((1 << AREA_W) != NUM_AREAS) begin : g_bad_areas
      initial $error("NUM_AREAS must be a power of two");
   end

   logic [CNT_W-1:0] gap_cnt;
   logic             has_prev;

   bidl_cfg_reg #(.REG_W(REG_W), .RESET_VAL(RESET_VAL)) cfg_i (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata)
   );

   bidl_decide #(.NUM_AREAS(NUM_AREAS)) decide_i (
      .idle_codes(cfg_rdata[REG_W-1:IDLE_LSB]),
      .has_prev(has_prev),
      .prev_area(bus_area),
      .prev_write(bus_write),
      .req_area(req_area),
      .req_write(req_write),
      .gap_cnt(gap_cnt)
   );

   bidl_gap_fsm #(.AREA_W(AREA_W)) fsm_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_area(req_area), .req_write(req_write),
      .gap_cnt(gap_cnt),
      .req_ready(req_ready), .bus_start(bus_start), .bus_area(bus_area),
      .bus_write(bus_write), .idle_active(idle_active), .has_prev(has_prev)
   );

   logic [FIELD_W-1:0] prev_code;
   logic               take;
   assign prev_code = cfg_rdata[IDLE_LSB + FIELD_W*bus_area +: FIELD_W];
   assign take      = req_valid && req_ready && has_prev;

   AST_SAME_KIND_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_area == bus_area && !(!bus_write && req_write)) |=> bus_start); // R6
   AST_AREA_CHANGE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_area != bus_area && prev_code != '0) |=> idle_active); // R4
   AST_RD_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_area == bus_area && !bus_write && req_write && prev_code != '0) |=> idle_active); // R5
   AST_FIRST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !has_prev) |=> bus_start); // R6
endmodule

// File: tb/bus_idle_gap_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_idle_gap_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_we = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_area = '0;
   logic        req_write = 1'b0;
   logic        req_ready, bus_start, bus_write, idle_active;
   logic [1:0]  bus_area;

   int errors = 0;
   int checks = 0;

   // Bench model of the register and the last issued access
   logic [15:0] m_reg = 16'hAAFF;
   logic [1:0]  m_area = '0;
   logic        m_wr = 1'b0;
   logic        m_has = 1'b0;

   always #2.5 clk = ~clk;

   bus_idle_gap_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_area(req_area),
      .req_write(req_write), .req_ready(req_ready), .bus_start(bus_start),
      .bus_area(bus_area), .bus_write(bus_write), .idle_active(idle_active)
   );

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int code_to_n(input logic [1:0] c);
      if (c == 2'b11) return 4;
      return int'(c);
   endfunction

   function automatic int model_idles(input logic [1:0] area, input logic wr);
      if (!m_has) return 0;
      if (area != m_area || (!m_wr && wr))
         return code_to_n(m_reg[8 + 2*m_area +: 2]);
      return 0;
   endfunction

   task automatic reg_write(input logic [1:0] we, input logic [15:0] d, input string tag);
      @(negedge clk);
      cfg_we = we; cfg_wdata = d;
      @(negedge clk);
      cfg_we = '0;
      if (we[1]) m_reg[15:8] = d[15:8];
      if (we[0]) m_reg[7:0]  = d[7:0];
      check(tag, cfg_rdata, m_reg);
   endtask

   // mode 0: plain, 1: register write in acceptance cycle, 2: register write in first idle cycle
   task automatic access(input logic [1:0] area, input logic wr, input int mode,
                         input logic [15:0] newcfg, input string tag);
      int exp_n, got_n, guard;
      exp_n = model_idles(area, wr);
      @(negedge clk);
      check({tag, " ready before accept"}, req_ready, 1);
      req_valid = 1'b1; req_area = area; req_write = wr;
      if (mode == 1) begin cfg_we = 2'b11; cfg_wdata = newcfg; end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_area = ~area; req_write = ~wr; cfg_we = '0;
      if (mode == 2) begin cfg_we = 2'b11; cfg_wdata = newcfg; end
      if (mode != 0) m_reg = newcfg;
      got_n = 0; guard = 0;
      while (!bus_start && guard < 12) begin
         if (idle_active && !req_ready) got_n++;
         @(negedge clk);
         cfg_we = '0;
         guard++;
      end
      cfg_we = '0;
      check({tag, " idle count"}, got_n, exp_n);
      check({tag, " R7 start seen"}, bus_start, 1);
      check({tag, " R8 area"}, bus_area, area);
      check({tag, " R8 dir"}, bus_write, wr);
      check({tag, " R7 ready at start"}, req_ready, 1);
      m_area = area; m_wr = wr; m_has = 1'b1;
      @(negedge clk);
      check({tag, " R7 single pulse"}, bus_start, 0);
   endtask

   task automatic t_reset;
      check("R1 rdata", cfg_rdata, 16'hAAFF);
      check("R1 ready", req_ready, 1);
      check("R1 start", bus_start, 0);
      check("R1 idle", idle_active, 0);
   endtask

   task automatic t_default_codes;
      access(2'd0, 1'b0, 0, '0, "R6 first after reset");
      access(2'd0, 1'b1, 0, '0, "R5 read->write same area");
      access(2'd0, 1'b1, 0, '0, "R6 write->write");
      access(2'd0, 1'b0, 0, '0, "R6 write->read");
      access(2'd0, 1'b0, 0, '0, "R6 read->read");
      access(2'd1, 1'b0, 0, '0, "R4 area change default");
   endtask

   task automatic t_reg_bytes;
      reg_write(2'b10, 16'h1B00, "R2 high byte only");
      reg_write(2'b01, 16'h0012, "R2 low byte only");
   endtask

   task automatic t_encodings;
      access(2'd0, 1'b0, 0, '0, "R3 prev area1 code 10");
      access(2'd3, 1'b0, 0, '0, "R3 prev area0 code 11");
      access(2'd2, 1'b0, 0, '0, "R3 prev area3 code 00");
      access(2'd1, 1'b0, 0, '0, "R3 prev area2 code 01");
   endtask

   task automatic t_cfg_isolation;
      access(2'd0, 1'b0, 1, 16'h1312, "R9 write at accept");
      access(2'd1, 1'b0, 2, 16'h1012, "R9 write during gap");
      access(2'd0, 1'b0, 0, '0, "R9 new area1 code applies");
      access(2'd0, 1'b1, 0, '0, "R5 zero code rd->wr");
   endtask

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_codes();
      t_reg_bytes();
      t_encodings();
      t_cfg_isolation();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule